// File: doc/BRIEF.md
# Temperature-Driven Fan PWM Controller

This block drives a cooling fan with a pulse-width-modulated signal. The pulse width comes either from a five-level temperature ladder or from a width that software writes directly. Each step of the ladder has its own rising and falling threshold, so the fan does not toggle between two speeds when the temperature sits near a boundary. The live temperature code uses a different scale from the threshold registers, and the block converts it before comparing. A free-running counter sets the PWM period. That period is fixed by a parameter and is reported on a read-only output.

When the ladder moves up a level, the block pulses a temperature-rise event at once. The new width is adopted at the next period boundary. A second event, duty-changed, fires only after a settle delay measured in clock cycles, which gives the fan time to reach its new speed. A software width write and a ladder step down also raise duty-changed, but it fires on the cycle the new width is adopted, with no delay. Until the run-enable bit is set, the block holds the fan at full duty and stays silent.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: `period_val` always equals the parameter PERIOD (nonzero). `active_width` never exceeds PERIOD.
- R2: A period counter runs from 0 to PERIOD-1 and wraps. While running, `pwm_out` is high exactly when the counter is below `active_width`. A new width is adopted only on the cycle the counter wraps to 0.
- R3: Ladder level k (0..4) requests the width floor(k*PERIOD/4), giving 0%, 25%, 50%, 75% and 100% duty.
- R4: At level L<4, if the converted temperature is strictly greater than the rising threshold of that step (L=0: `thr_q1_lo`, 1: `thr_q2_lo`, 2: `thr_q3_lo`, 3: `thr_full_lo`), the level rises by one on that clock. The ladder moves at most one level per clock.
- R5: At level L>0 with no rise, if the converted temperature is strictly below the falling threshold (L=1: `thr_off_hi`, 2: `thr_q1_hi`, 3: `thr_q2_hi`, 4: `thr_q3_hi`), the level falls by one. Between the two thresholds the level holds.
- R6: The converted temperature is floor(temp_code*64513/65536)+843. This places the live code on the threshold scale.
- R7: `temp_up_evt` is a one-cycle pulse in the cycle after each upward ladder step.
- R8: When the adopted width came from an upward ladder step, `pwm_chg_evt` pulses once, SETTLE_CYC cycles after `active_width` changes.
- R9: A `sw_wr` strobe while running requests `sw_width`, saturated to PERIOD. It takes priority over a ladder request in the same cycle. Its adoption raises `pwm_chg_evt` in the same cycle `active_width` changes, and no `temp_up_evt` comes with it.
- R10: A downward ladder step raises `pwm_chg_evt` on adoption with no delay. A newer request replaces an unadopted one, and any adoption cancels an outstanding settle countdown.
- R11: While `run_en` is 0, the block is held in reset: `pwm_out`=1, `active_width`=PERIOD, level 0, no events, and `sw_wr` is ignored. After release, the first wrap adopts the level-0 width without raising `pwm_chg_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run-enable bit; 0 holds the block in reset |
| temp_code | input | 16 | Live temperature code |
| thr_off_hi | input | 16 | Falling threshold into 0% |
| thr_q1_lo | input | 16 | Rising threshold into 25% |
| thr_q1_hi | input | 16 | Falling threshold into 25% |
| thr_q2_lo | input | 16 | Rising threshold into 50% |
| thr_q2_hi | input | 16 | Falling threshold into 50% |
| thr_q3_lo | input | 16 | Rising threshold into 75% |
| thr_q3_hi | input | 16 | Falling threshold into 75% |
| thr_full_lo | input | 16 | Rising threshold into 100% |
| sw_wr | input | 1 | Software width write strobe |
| sw_width | input | $clog2(PERIOD+1) | Software pulse width in clock cycles |
| pwm_out | output | 1 | Fan PWM signal |
| period_val | output | $clog2(PERIOD+1) | Read-only PWM period |
| active_width | output | $clog2(PERIOD+1) | Width currently in effect |
| temp_up_evt | output | 1 | Pulse: ladder raised the duty |
| pwm_chg_evt | output | 1 | Pulse: new duty adopted (and settled, for ladder raises) |

## Verification
Some properties are checked on every cycle by assertions:
- the held-reset state and event silence while `run_en` is low;
- the width bound;
- widths changing only at a counter wrap;
- the ladder moving by at most one level;
- every rise event matching a one-level climb.

Other behaviour needs the bench's scenarios and its cycle-level model:
- the exact conversion near a threshold;
- hysteresis holding inside the band;
- the settle gap of exactly SETTLE_CYC cycles;
- immediate events for software writes and steps down;
- saturation of oversized writes;
- cancellation of a pending settle by a later software write.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
    localparam int TEMP_W   = 16;
    localparam int N_STEPS  = 4;
    localparam int CONV_MUL = 64513;
    localparam int CONV_OFS = 843;

    typedef enum logic [2:0] {
        REQ_NONE = 3'd0,
        REQ_INIT = 3'd1,
        REQ_SW   = 3'd2,
        REQ_UP   = 3'd3,
        REQ_DN   = 3'd4
    } req_kind_e;

    // live sensor code -> threshold register scale
    function automatic logic [TEMP_W:0] to_thr_scale(input logic [TEMP_W-1:0] code);
        logic [TEMP_W+16:0] prod;
        prod = (TEMP_W+17)'(code) * (TEMP_W+17)'(CONV_MUL);
        return (TEMP_W+1)'(prod >> 16) + (TEMP_W+1)'(CONV_OFS);
    endfunction
endpackage

// File: rtl/fan_temp_ladder.sv
module fan_temp_ladder
    import fan_pwm_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             run,
    input  logic [TEMP_W-1:0]                temp_code,
    input  logic [N_STEPS-1:0][TEMP_W-1:0]   rise_thr,
    input  logic [N_STEPS-1:0][TEMP_W-1:0]   fall_thr,
    output logic [2:0]                       level_o,
    output logic                             step_up_o,
    output logic                             step_dn_o
);
    typedef struct packed {
        logic [2:0] lvl;
    } ladder_t;

    ladder_t q, d;
    logic [TEMP_W:0] conv;
    logic [1:0]      up_idx, dn_idx;
    logic [2:0]      lvl_m1;

    always_comb begin
        conv      = to_thr_scale(temp_code);
        lvl_m1    = q.lvl - 3'd1;
        up_idx    = q.lvl[1:0];
        dn_idx    = lvl_m1[1:0];
        d         = q;
        step_up_o = 1'b0;
        step_dn_o = 1'b0;
        if (!run) begin
            d.lvl = 3'd0;
        end else if (q.lvl < 3'(N_STEPS) && conv > {1'b0, rise_thr[up_idx]}) begin
            d.lvl     = q.lvl + 3'd1;
            step_up_o = 1'b1;
        end else if (q.lvl != 3'd0 && conv < {1'b0, fall_thr[dn_idx]}) begin
            d.lvl     = lvl_m1;
            step_dn_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.lvl;
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core
    import fan_pwm_pkg::*;
#(
    parameter int PERIOD = 4000,
    localparam int WW = $clog2(PERIOD + 1),
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          req_valid,
    input  logic [WW-1:0] req_width,
    input  req_kind_e     req_kind,
    output logic          pwm_o,
    output logic [WW-1:0] act_o,
    output logic          adopt_o,
    output req_kind_e     adopt_kind_o
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [WW-1:0] act;
        logic          pend_v;
        logic [WW-1:0] pend_w;
        req_kind_e     pend_k;
    } core_t;

    core_t q, d;
    logic          eff_v, wrap;
    logic [WW-1:0] eff_w;
    req_kind_e     eff_k;
    logic [CW-1:0] cnt_now;

    always_comb begin
        eff_v        = req_valid | q.pend_v;
        eff_w        = req_valid ? req_width : q.pend_w;
        eff_k        = req_valid ? req_kind  : q.pend_k;
        wrap         = (q.cnt == CW'(PERIOD - 1));
        d            = q;
        adopt_o      = 1'b0;
        adopt_kind_o = eff_k;
        if (!run) begin
            d.run    = 1'b0;
            d.cnt    = '0;
            d.act    = WW'(PERIOD);
            d.pend_v = 1'b1;
            d.pend_w = '0;
            d.pend_k = REQ_INIT;
        end else begin
            d.run = 1'b1;
            d.cnt = wrap ? '0 : q.cnt + CW'(1);
            if (wrap && eff_v) begin
                d.act    = eff_w;
                d.pend_v = 1'b0;
                adopt_o  = 1'b1;
            end else begin
                d.pend_v = eff_v;
                d.pend_w = eff_w;
                d.pend_k = eff_k;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.act    <= WW'(PERIOD);
            q.pend_v <= 1'b1;
            q.pend_k <= REQ_INIT;
        end else begin
            q <= d;
        end
    end

    assign cnt_now = q.cnt;
    assign act_o   = q.act;
    assign pwm_o   = !q.run || ({1'b0, q.cnt} < (CW+1)'(q.act));
endmodule

// File: rtl/fan_event_seq.sv
module fan_event_seq
    import fan_pwm_pkg::*;
#(
    parameter int SETTLE_CYC = 500000000,
    localparam int SW = $clog2(SETTLE_CYC + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      adopt,
    input  req_kind_e adopt_kind,
    input  logic      step_up,
    output logic      up_evt_o,
    output logic      chg_evt_o
);
    typedef struct packed {
        logic [SW-1:0] settle;
        logic          chg;
        logic          up;
    } evt_t;

    evt_t q, d;

    always_comb begin
        d = q;
        if (!run) begin
            d = '0;
        end else begin
            d.up = step_up;
            if (adopt) begin
                d.settle = (adopt_kind == REQ_UP) ? SW'(SETTLE_CYC) : '0;
                d.chg    = (adopt_kind == REQ_SW) || (adopt_kind == REQ_DN);
            end else begin
                d.chg    = (q.settle == SW'(1));
                d.settle = (q.settle != '0) ? q.settle - SW'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign up_evt_o  = q.up;
    assign chg_evt_o = q.chg;
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int PERIOD     = 4000,
    parameter int SETTLE_CYC = 500000000,
    localparam int WW = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] thr_off_hi,
    input  logic [TEMP_W-1:0] thr_q1_lo,
    input  logic [TEMP_W-1:0] thr_q1_hi,
    input  logic [TEMP_W-1:0] thr_q2_lo,
    input  logic [TEMP_W-1:0] thr_q2_hi,
    input  logic [TEMP_W-1:0] thr_q3_lo,
    input  logic [TEMP_W-1:0] thr_q3_hi,
    input  logic [TEMP_W-1:0] thr_full_lo,
    input  logic              sw_wr,
    input  logic [WW-1:0]     sw_width,
    output logic              pwm_out,
    output logic [WW-1:0]     period_val,
    output logic [WW-1:0]     active_width,
    output logic              temp_up_evt,
    output logic              pwm_chg_evt
);
    logic [N_STEPS-1:0][TEMP_W-1:0] rise_thr, fall_thr;
    logic [WW-1:0] lvl_w [N_STEPS+1];
    logic [2:0]    level;
    logic          step_up, step_dn;
    logic          req_valid, adopt;
    logic [WW-1:0] req_width, sw_clamped;
    req_kind_e     req_kind, adopt_kind;

    assign rise_thr = {thr_full_lo, thr_q3_lo, thr_q2_lo, thr_q1_lo};
    assign fall_thr = {thr_q3_hi,   thr_q2_hi, thr_q1_hi, thr_off_hi};

    for (genvar k = 0; k <= N_STEPS; k++) begin : g_lvl_w
        assign lvl_w[k] = WW'((k * PERIOD) / N_STEPS);
    end

    fan_temp_ladder u_ladder (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_en),
        .temp_code (temp_code),
        .rise_thr  (rise_thr),
        .fall_thr  (fall_thr),
        .level_o   (level),
        .step_up_o (step_up),
        .step_dn_o (step_dn)
    );

    always_comb begin
        sw_clamped = (sw_width > WW'(PERIOD)) ? WW'(PERIOD) : sw_width;
        req_valid  = 1'b0;
        req_width  = '0;
        req_kind   = REQ_NONE;
        if (run_en && sw_wr) begin
            req_valid = 1'b1;
            req_width = sw_clamped;
            req_kind  = REQ_SW;
        end else if (step_up) begin
            req_valid = 1'b1;
            req_width = lvl_w[level + 3'd1];
            req_kind  = REQ_UP;
        end else if (step_dn) begin
            req_valid = 1'b1;
            req_width = lvl_w[level - 3'd1];
            req_kind  = REQ_DN;
        end
    end

    fan_pwm_core #(.PERIOD(PERIOD)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run_en),
        .req_valid    (req_valid),
        .req_width    (req_width),
        .req_kind     (req_kind),
        .pwm_o        (pwm_out),
        .act_o        (active_width),
        .adopt_o      (adopt),
        .adopt_kind_o (adopt_kind)
    );

    fan_event_seq #(.SETTLE_CYC(SETTLE_CYC)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_en),
        .adopt      (adopt),
        .adopt_kind (adopt_kind),
        .step_up    (step_up),
        .up_evt_o   (temp_up_evt),
        .chg_evt_o  (pwm_chg_evt)
    );

    assign period_val = WW'(PERIOD);
endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk #(
    parameter int PERIOD = 4000,
    localparam int WW = $clog2(PERIOD + 1),
    localparam int CW = $clog2(PERIOD)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          pwm_out,
    input logic [WW-1:0] active_width,
    input logic          temp_up_evt,
    input logic          pwm_chg_evt,
    input logic [CW-1:0] cnt_i,
    input logic [2:0]    level_i
);
    AST_HELD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (pwm_out && active_width == WW'(PERIOD))); // R11
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> (!temp_up_evt && !pwm_chg_evt)); // R11
    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        active_width <= WW'(PERIOD)); // R1
    AST_ADOPT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en) && active_width != $past(active_width)) |-> cnt_i == '0); // R2
    AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en) |-> (level_i == $past(level_i) || level_i == 3'($past(level_i) + 3'd1)
                           || level_i == 3'($past(level_i) - 3'd1))); // R4
    AST_UP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        temp_up_evt |-> level_i == 3'($past(level_i) + 3'd1)); // R7
endmodule

bind fan_pwm_ctrl fan_pwm_chk #(.PERIOD(PERIOD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .pwm_out      (pwm_out),
    .active_width (active_width),
    .temp_up_evt  (temp_up_evt),
    .pwm_chg_evt  (pwm_chg_evt),
    .cnt_i        (u_core.cnt_now),
    .level_i      (level)
);

// File: tb/tb_fan_pwm_ctrl.sv
module tb_fan_pwm_ctrl;
    localparam int P  = 8;
    localparam int S  = 20;
    localparam int WW = $clog2(P + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [15:0] temp_code = 16'd10000;
    logic [15:0] thr_off_hi = 16'd18000, thr_q1_lo = 16'd20000, thr_q1_hi = 16'd23000,
                 thr_q2_lo = 16'd25000, thr_q2_hi = 16'd28000, thr_q3_lo = 16'd30000,
                 thr_q3_hi = 16'd33000, thr_full_lo = 16'd35000;
    logic sw_wr = 1'b0;
    logic [WW-1:0] sw_width = '0;
    logic pwm_out, temp_up_evt, pwm_chg_evt;
    logic [WW-1:0] period_val, active_width;

    always #5 clk = ~clk;

    fan_pwm_ctrl #(.PERIOD(P), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .temp_code(temp_code),
        .thr_off_hi(thr_off_hi), .thr_q1_lo(thr_q1_lo), .thr_q1_hi(thr_q1_hi),
        .thr_q2_lo(thr_q2_lo), .thr_q2_hi(thr_q2_hi), .thr_q3_lo(thr_q3_lo),
        .thr_q3_hi(thr_q3_hi), .thr_full_lo(thr_full_lo), .sw_wr(sw_wr),
        .sw_width(sw_width), .pwm_out(pwm_out), .period_val(period_val),
        .active_width(active_width), .temp_up_evt(temp_up_evt), .pwm_chg_evt(pwm_chg_evt)
    );

    int total = 0, bad = 0;
    bit done = 0, cmp_on = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: kinds 0 none, 1 init, 2 sw, 3 up, 4 down
    int m_run, m_cnt, m_act, m_lvl, m_pv, m_pw, m_pk, m_settle, m_chg, m_up;
    int rise[4], fall[4];

    function automatic int conv(input int c);
        longint p;
        p = longint'(c) * 64513;
        return int'(p / 65536) + 843;
    endfunction

    task automatic model_reset();
        m_run = 0; m_cnt = 0; m_act = P; m_lvl = 0; m_pv = 1; m_pw = 0; m_pk = 1;
        m_settle = 0; m_chg = 0; m_up = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n || !run_en) begin
            model_reset();
        end else begin
            int t, rv, rw, rk, ev, ew, ek;
            bit up, dn;
            rise[0] = thr_q1_lo; rise[1] = thr_q2_lo; rise[2] = thr_q3_lo; rise[3] = thr_full_lo;
            fall[0] = thr_off_hi; fall[1] = thr_q1_hi; fall[2] = thr_q2_hi; fall[3] = thr_q3_hi;
            t = conv(int'(temp_code));
            up = 0; dn = 0;
            if (m_lvl < 4 && t > rise[m_lvl]) up = 1;
            else if (m_lvl > 0 && t < fall[m_lvl-1]) dn = 1;
            rv = 0; rw = 0; rk = 0;
            if (sw_wr) begin rv = 1; rw = (int'(sw_width) > P) ? P : int'(sw_width); rk = 2; end
            else if (up) begin rv = 1; rw = ((m_lvl + 1) * P) / 4; rk = 3; end
            else if (dn) begin rv = 1; rw = ((m_lvl - 1) * P) / 4; rk = 4; end
            if (up) m_lvl++;
            else if (dn) m_lvl--;
            ev = rv | m_pv; ew = rv ? rw : m_pw; ek = rv ? rk : m_pk;
            if (m_cnt == P - 1 && ev != 0) begin
                m_act = ew; m_pv = 0;
                if (ek == 3) begin m_settle = S; m_chg = 0; end
                else begin m_settle = 0; m_chg = (ek == 2 || ek == 4) ? 1 : 0; end
            end else begin
                m_pv = ev; m_pw = ew; m_pk = ek;
                m_chg = (m_settle == 1) ? 1 : 0;
                if (m_settle > 0) m_settle--;
            end
            m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
            m_up = up;
            m_run = 1;
        end
    end

    // per-cycle comparison and event monitors
    int cyc = 0, up_cnt = 0, chg_cnt = 0, last_act_cyc = 0, last_gap = -1, prev_act = P;
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            int ep;
            ep = (m_run == 0) ? 1 : ((m_cnt < m_act) ? 1 : 0);
            chk(pwm_out == ep[0], "R2 pwm_out", int'(pwm_out), ep);
            chk(int'(active_width) == m_act, "R3 active_width", int'(active_width), m_act);
            chk(temp_up_evt == m_up[0], "R7 temp_up_evt", int'(temp_up_evt), m_up);
            chk(pwm_chg_evt == m_chg[0], "R8 pwm_chg_evt", int'(pwm_chg_evt), m_chg);
            if (int'(active_width) != prev_act) last_act_cyc = cyc;
            prev_act = int'(active_width);
            if (temp_up_evt) up_cnt++;
            if (pwm_chg_evt) begin chg_cnt++; last_gap = cyc - last_act_cyc; end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(input int w);
        @(negedge clk); #1;
        sw_wr = 1'b1; sw_width = WW'(w);
        @(negedge clk); #1;
        sw_wr = 1'b0;
    endtask

    task automatic set_temp(input int c);
        @(negedge clk); #1;
        temp_code = 16'(c);
    endtask

    initial begin
        int c0, u0, hi;
        wait_cyc(3);
        cmp_on = 1;
        #1 rst_n = 1'b1;
        wait_cyc(3);
        sw_write(5);
        wait_cyc(3);
        chk(active_width == WW'(P), "R11 width held", int'(active_width), P);
        chk(pwm_out == 1'b1, "R11 pwm held high", int'(pwm_out), 1);
        chk(period_val == WW'(P), "R1 period_val", int'(period_val), P);
        #1 run_en = 1'b1;
        wait_cyc(12);
        chk(active_width == 0, "R11 init width", int'(active_width), 0);
        chk(chg_cnt == 0, "R11 silent init", chg_cnt, 0);

        set_temp(19200);
        wait_cyc(20);
        chk(active_width == 0, "R6 below threshold", int'(active_width), 0);
        chk(up_cnt == 0, "R6 no rise", up_cnt, 0);
        set_temp(19500);
        wait_cyc(40);
        chk(active_width == WW'(P/4), "R3 level1 width", int'(active_width), P/4);
        chk(up_cnt == 1, "R7 one rise pulse", up_cnt, 1);
        chk(last_gap == S, "R8 settle gap", last_gap, S);

        set_temp(40000);
        wait_cyc(50);
        chk(active_width == WW'(P), "R4 top level", int'(active_width), P);
        chk(up_cnt == 4, "R4 rise count", up_cnt, 4);

        set_temp(26000);
        wait_cyc(30);
        chk(active_width == WW'(P/2), "R5 hysteresis hold", int'(active_width), P/2);
        chk(last_gap == 0, "R10 down no delay", last_gap, 0);
        hi = 0;
        @(negedge clk);
        while (dut.u_core.pwm_o === 1'bx) @(negedge clk);
        for (int i = 0; i < P; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
        chk(hi == P/2, "R2 high cycles per period", hi, P/2);

        u0 = up_cnt; c0 = chg_cnt;
        sw_write(5);
        wait_cyc(20);
        chk(active_width == 5, "R9 sw width", int'(active_width), 5);
        chk(up_cnt == u0, "R9 no rise event", up_cnt, u0);
        chk(chg_cnt == c0 + 1 && last_gap == 0, "R9 immediate chg", chg_cnt, c0 + 1);
        sw_write(15);
        wait_cyc(20);
        chk(active_width == WW'(P), "R9 saturate", int'(active_width), P);

        sw_write(2);
        wait_cyc(12);
        set_temp(40000);
        wait_cyc(12);
        c0 = chg_cnt;
        sw_write(3);
        wait_cyc(40);
        chk(active_width == 3, "R10 sw after raise", int'(active_width), 3);
        chk(chg_cnt == c0 + 1, "R10 settle cancelled", chg_cnt, c0 + 1);

        #1 run_en = 1'b0;
        wait_cyc(3);
        chk(pwm_out == 1'b1 && active_width == WW'(P), "R11 re-held", int'(active_width), P);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule